// File: doc/BRIEF.md
# Bordered-Board Chess Move Generator

This block lists the pseudo-legal destination squares of one chess piece. The position is held inside the block as a 12 by 12 grid of 4-bit cells. The 8 by 8 playing area sits in the middle of the grid, and a ring two cells wide surrounds it. Every ring cell holds a dedicated boundary code. A move that leaves the board is recognised because its target cell reads as boundary, so no row or column comparison is needed anywhere. The largest jump of any piece stays inside the grid because the ring is two cells wide.

Software or a loader fills the grid through a write port. A one-cycle start strobe then names a source square. The sequencer reads the piece on that square and walks its direction list. It offers one candidate move per accepted transfer on a valid/ready handshake and pulses done when the list is exhausted. Each candidate carries the source index, the destination index and a capture flag.

The sequencer has four states:
- IDLE waits for start. It goes to FIN when the source cell is empty or boundary, and to STEP otherwise.
- STEP probes one target cell. It goes to EMIT when the target yields a move. When it does not, it moves to the next direction, or to FIN after the last direction.
- EMIT holds the move until ready is high. It then goes back to STEP, either to continue the same ray or to start the next direction, or to FIN after the last direction.
- FIN drives done for one cycle and returns to IDLE.

Top module: `piece_move_gen`

## Requirements
- R1: Synchronous active-high reset sends the sequencer to IDLE, with mv_valid and done low in the cycle after it. Cell contents written before the reset are still there after it.
- R2: Cell encoding is bits [2:0] kind and bit 3 side (0 white, 1 black). The kinds are 0 empty, 1 pawn, 2 rook, 3 knight, 4 bishop, 5 queen, 6 king and 7 boundary. A square index is row*12+col. The playing area is rows and columns 2 to 9, and every other cell must hold kind 7.
- R3: A start on a square holding empty or boundary raises done in the very next cycle, and no move is emitted.
- R4: Rook, bishop and queen slide along their rays (rook ±1 and ±12, bishop ±11 and ±13, queen all eight) over empty cells. Each empty cell is emitted with capture 0. A ray stops at a boundary cell, which is not emitted. It also stops at an own piece, which is not emitted, or at an enemy piece, which is emitted with capture 1.
- R5: Knight (±10, ±14, ±23, ±25) and king (the eight neighbours) take single steps. Boundary and own-piece targets are skipped. An enemy target is emitted with capture 1.
- R6: A pawn moves one row forward onto an empty cell, with white going toward lower row numbers. From its home row (row 8 for white, row 3 for black) it may also move two rows forward, but only when both cells are empty.
- R7: A pawn moves diagonally forward only onto an enemy piece, flagged as a capture. An empty or own diagonal gives no move.
- R8: While mv_valid is high and mv_ready is low, mv_valid, mv_src, mv_dst and mv_capture hold their values.
- R9: done lasts exactly one cycle and follows the last accepted move. A start strobe while a generation is running is ignored. Every emitted move carries the started square as mv_src.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| wr_en | input | 1 | Cell write strobe |
| wr_idx | input | 8 | Index of the cell to write |
| wr_cell | input | 4 | Cell value {side, kind} |
| start | input | 1 | Begin generation for start_idx (used only in IDLE) |
| start_idx | input | 8 | Source square index |
| mv_valid | output | 1 | A candidate move is offered |
| mv_ready | input | 1 | Consumer accepts the offered move |
| mv_src | output | 8 | Source square of the move |
| mv_dst | output | 8 | Destination square of the move |
| mv_capture | output | 1 | Destination holds an enemy piece |
| done | output | 1 | One-cycle pulse: enumeration finished |

## Verification
The bench goes after the cells where a ray must stop. A design that emitted the boundary cell or its own blocker would report too many moves. A design that failed to flag the enemy piece, or failed to stop after it, would show a missing capture or moves behind the enemy.

The bench also covers pawn corner cases:
- a double push blocked at the first or the second cell;
- a double push from a square that is not the home row;
- diagonals holding an own piece or nothing.

An implementation that confused the sides or skipped the emptiness test would emit moves that are not on the expected list.

Stalled handshakes and a start strobe injected in the middle of a run expose a sequencer that drifts or restarts. An empty source square checks that done arrives in the next cycle rather than after a walk of the direction list.

// File: rtl/mvgen_pkg.sv
package mvgen_pkg;

    // Piece kind stored in the low three bits of a cell
    typedef enum logic [2:0] {
        K_EMPTY  = 3'd0,
        K_PAWN   = 3'd1,
        K_ROOK   = 3'd2,
        K_KNIGHT = 3'd3,
        K_BISHOP = 3'd4,
        K_QUEEN  = 3'd5,
        K_KING   = 3'd6,
        K_EDGE   = 3'd7
    } kind_e;

    // One board cell: side bit above the kind
    typedef struct packed {
        logic  black;
        kind_e kind;
    } cell_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_STEP = 2'd1,
        S_EMIT = 2'd2,
        S_FIN  = 2'd3
    } seq_state_e;

    localparam int OFF_W = 7;  // signed offset width, covers +-(2*SIDE+1)

endpackage

// File: rtl/mvgen_board.sv
module mvgen_board #(
    parameter int CELLS = 144,
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  mvgen_pkg::cell_t     wr_cell,
    input  logic [IDX_W-1:0]     rd_idx,
    output mvgen_pkg::cell_t     rd_cell
);
    import mvgen_pkg::*;

    // Cell storage has no reset: position survives a sequencer reset
    logic [3:0] cells_q [CELLS];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_idx) < CELLS)) begin
            cells_q[wr_idx] <= wr_cell;
        end
    end

    // Indices beyond the grid read as boundary
    always_comb begin
        if (32'(rd_idx) < CELLS) begin
            rd_cell = cell_t'(cells_q[rd_idx]);
        end else begin
            rd_cell = cell_t'({1'b0, K_EDGE});
        end
    end

endmodule

// File: rtl/mvgen_dirtab.sv
module mvgen_dirtab #(
    parameter int SIDE = 12
) (
    input  mvgen_pkg::kind_e                kind,
    input  logic                            black,
    input  logic [2:0]                      dir,
    output logic signed [mvgen_pkg::OFF_W-1:0] off,
    output logic [3:0]                      count
);
    import mvgen_pkg::*;

    // Eight ray offsets: orthogonal first, then diagonal
    function automatic int ray_off(input logic [2:0] d);
        case (d)
            3'd0:    return 1;
            3'd1:    return -1;
            3'd2:    return SIDE;
            3'd3:    return -SIDE;
            3'd4:    return SIDE - 1;
            3'd5:    return -(SIDE - 1);
            3'd6:    return SIDE + 1;
            default: return -(SIDE + 1);
        endcase
    endfunction

    // Knight jumps: one row two columns, or two rows one column
    function automatic int jump_off(input logic [2:0] d);
        case (d)
            3'd0:    return SIDE - 2;
            3'd1:    return -(SIDE - 2);
            3'd2:    return SIDE + 2;
            3'd3:    return -(SIDE + 2);
            3'd4:    return 2 * SIDE - 1;
            3'd5:    return -(2 * SIDE - 1);
            3'd6:    return 2 * SIDE + 1;
            default: return -(2 * SIDE + 1);
        endcase
    endfunction

    // Pawn: slot 0 push, slots 1 and 2 diagonal captures
    function automatic int pawn_off(input logic [2:0] d, input logic blk);
        int fwd;
        fwd = blk ? SIDE : -SIDE;
        case (d)
            3'd0:    return fwd;
            3'd1:    return fwd - 1;
            default: return fwd + 1;
        endcase
    endfunction

    int off_i;

    always_comb begin
        off_i = 0;
        count = 4'd0;
        unique case (kind)
            K_PAWN:   begin off_i = pawn_off(dir, black); count = 4'd3; end
            K_ROOK:   begin off_i = ray_off(dir);          count = 4'd4; end
            K_BISHOP: begin off_i = ray_off(dir + 3'd4);   count = 4'd4; end
            K_KNIGHT: begin off_i = jump_off(dir);         count = 4'd8; end
            K_QUEEN,
            K_KING:   begin off_i = ray_off(dir);          count = 4'd8; end
            default:  begin off_i = 0;                     count = 4'd0; end
        endcase
        off = OFF_W'(off_i);
    end

endmodule

// File: rtl/mvgen_seq.sv
module mvgen_seq #(
    parameter int SIDE   = 12,
    parameter int BORDER = 2,
    parameter int RANKS  = 8,
    parameter int IDX_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [IDX_W-1:0]        start_idx,
    output logic [IDX_W-1:0]        rd_idx,
    input  mvgen_pkg::cell_t        rd_cell,
    output mvgen_pkg::kind_e        dir_kind,
    output logic                    dir_black,
    output logic [2:0]              dir_idx,
    input  logic signed [mvgen_pkg::OFF_W-1:0] dir_off,
    input  logic [3:0]              dir_cnt,
    output logic                    mv_valid,
    input  logic                    mv_ready,
    output logic [IDX_W-1:0]        mv_src,
    output logic [IDX_W-1:0]        mv_dst,
    output logic                    mv_capture,
    output logic                    done
);
    import mvgen_pkg::*;

    localparam int WHITE_HOME = BORDER + RANKS - 2;
    localparam int BLACK_HOME = BORDER + 1;
    localparam logic [IDX_W-1:0] W_LO = IDX_W'(WHITE_HOME * SIDE);
    localparam logic [IDX_W-1:0] W_HI = IDX_W'((WHITE_HOME + 1) * SIDE);
    localparam logic [IDX_W-1:0] B_LO = IDX_W'(BLACK_HOME * SIDE);
    localparam logic [IDX_W-1:0] B_HI = IDX_W'((BLACK_HOME + 1) * SIDE);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] src_q, src_d;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [IDX_W-1:0] dst_q, dst_d;
    kind_e            kind_q, kind_d;
    logic             black_q, black_d;
    logic [2:0]       dir_q, dir_d;
    logic             hop_q, hop_d;
    logic             cap_q, cap_d;
    logic             cont_q, cont_d;

    // Probe of one target cell
    logic [IDX_W-1:0] off_ext;
    logic [IDX_W-1:0] step_dst;
    logic             t_empty, t_edge, t_enemy;
    logic             emit_c, cap_c, cont_c;
    logic             on_home, last_dir;

    assign off_ext  = {{(IDX_W-OFF_W){dir_off[OFF_W-1]}}, dir_off};
    assign step_dst = cur_q + off_ext;
    assign t_empty  = (rd_cell.kind == K_EMPTY);
    assign t_edge   = (rd_cell.kind == K_EDGE);
    assign t_enemy  = !t_empty && !t_edge && (rd_cell.black != black_q);
    assign on_home  = black_q ? (src_q >= B_LO && src_q < B_HI)
                              : (src_q >= W_LO && src_q < W_HI);
    assign last_dir = (dir_q == 3'(dir_cnt - 4'd1));

    always_comb begin
        emit_c = 1'b0;
        cap_c  = 1'b0;
        cont_c = 1'b0;
        unique case (kind_q)
            K_PAWN: begin
                if (dir_q == 3'd0) begin
                    emit_c = t_empty;
                    cont_c = t_empty && !hop_q && on_home;
                end else begin
                    emit_c = t_enemy;
                    cap_c  = t_enemy;
                end
            end
            K_ROOK, K_BISHOP, K_QUEEN: begin
                emit_c = t_empty || t_enemy;
                cap_c  = t_enemy;
                cont_c = t_empty;
            end
            K_KNIGHT, K_KING: begin
                emit_c = t_empty || t_enemy;
                cap_c  = t_enemy;
            end
            default: begin
                emit_c = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Walk registers: meaningful only outside IDLE
    always_ff @(posedge clk) begin
        src_q   <= src_d;
        cur_q   <= cur_d;
        dst_q   <= dst_d;
        kind_q  <= kind_d;
        black_q <= black_d;
        dir_q   <= dir_d;
        hop_q   <= hop_d;
        cap_q   <= cap_d;
        cont_q  <= cont_d;
    end

    // Next-state and walk update
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        cur_d   = cur_q;
        dst_d   = dst_q;
        kind_d  = kind_q;
        black_d = black_q;
        dir_d   = dir_q;
        hop_d   = hop_q;
        cap_d   = cap_q;
        cont_d  = cont_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    src_d   = start_idx;
                    cur_d   = start_idx;
                    kind_d  = rd_cell.kind;
                    black_d = rd_cell.black;
                    dir_d   = 3'd0;
                    hop_d   = 1'b0;
                    state_d = (t_empty || t_edge) ? S_FIN : S_STEP;
                end
            end
            S_STEP: begin
                if (emit_c) begin
                    dst_d   = step_dst;
                    cap_d   = cap_c;
                    cont_d  = cont_c;
                    state_d = S_EMIT;
                end else if (last_dir) begin
                    state_d = S_FIN;
                end else begin
                    dir_d   = dir_q + 3'd1;
                    cur_d   = src_q;
                    hop_d   = 1'b0;
                    state_d = S_STEP;
                end
            end
            S_EMIT: begin
                if (mv_ready) begin
                    if (cont_q) begin
                        cur_d   = dst_q;
                        hop_d   = 1'b1;
                        state_d = S_STEP;
                    end else if (last_dir) begin
                        state_d = S_FIN;
                    end else begin
                        dir_d   = dir_q + 3'd1;
                        cur_d   = src_q;
                        hop_d   = 1'b0;
                        state_d = S_STEP;
                    end
                end
            end
            S_FIN: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mv_valid   = (state_q == S_EMIT);
        done       = (state_q == S_FIN);
        mv_src     = src_q;
        mv_dst     = dst_q;
        mv_capture = cap_q;
        dir_kind   = kind_q;
        dir_black  = black_q;
        dir_idx    = dir_q;
        unique case (state_q)
            S_IDLE:  rd_idx = start_idx;
            S_EMIT:  rd_idx = dst_q;
            default: rd_idx = step_dst;
        endcase
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_src) && $stable(mv_dst) && $stable(mv_capture))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_VOID_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && start && (rd_cell.kind == K_EMPTY || rd_cell.kind == K_EDGE)) |=> (done && !mv_valid)); // R3
    AST_NO_EDGE_DST: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> (rd_cell.kind != K_EDGE)); // R4
    AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> (mv_capture == (rd_cell.kind != K_EMPTY))); // R5
    AST_CAPTURE_ENEMY: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && mv_capture) |-> (rd_cell.black != black_q)); // R7

endmodule

// File: rtl/piece_move_gen.sv
module piece_move_gen #(
    parameter int RANKS  = 8,
    parameter int BORDER = 2,
    localparam int SIDE  = RANKS + 2 * BORDER,
    localparam int CELLS = SIDE * SIDE,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [3:0]       wr_cell,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    output logic             mv_valid,
    input  logic             mv_ready,
    output logic [IDX_W-1:0] mv_src,
    output logic [IDX_W-1:0] mv_dst,
    output logic             mv_capture,
    output logic             done
);
    import mvgen_pkg::*;

    logic [IDX_W-1:0]         rd_idx;
    cell_t                    rd_cell;
    kind_e                    dir_kind;
    logic                     dir_black;
    logic [2:0]               dir_idx;
    logic signed [OFF_W-1:0]  dir_off;
    logic [3:0]               dir_cnt;

    mvgen_board #(.CELLS(CELLS), .IDX_W(IDX_W)) u_board (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_cell (cell_t'(wr_cell)),
        .rd_idx  (rd_idx),
        .rd_cell (rd_cell)
    );

    mvgen_dirtab #(.SIDE(SIDE)) u_dirtab (
        .kind  (dir_kind),
        .black (dir_black),
        .dir   (dir_idx),
        .off   (dir_off),
        .count (dir_cnt)
    );

    mvgen_seq #(.SIDE(SIDE), .BORDER(BORDER), .RANKS(RANKS), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_idx  (start_idx),
        .rd_idx     (rd_idx),
        .rd_cell    (rd_cell),
        .dir_kind   (dir_kind),
        .dir_black  (dir_black),
        .dir_idx    (dir_idx),
        .dir_off    (dir_off),
        .dir_cnt    (dir_cnt),
        .mv_valid   (mv_valid),
        .mv_ready   (mv_ready),
        .mv_src     (mv_src),
        .mv_dst     (mv_dst),
        .mv_capture (mv_capture),
        .done       (done)
    );

endmodule

// File: tb/test_piece_move_gen.sv
module test_piece_move_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_idx = '0;
    logic [3:0] wr_cell = '0;
    logic       start = 1'b0;
    logic [7:0] start_idx = '0;
    logic       mv_valid;
    logic       mv_ready = 1'b1;
    logic [7:0] mv_src;
    logic [7:0] mv_dst;
    logic       mv_capture;
    logic       done;

    int checks = 0;
    int errors = 0;
    int n_got = 0;
    int got_dst [64];
    int got_cap [64];
    int done_at = -1;

    // Cell codes (R2)
    localparam int PAWN = 1, ROOK = 2, KNIGHT = 3, BISHOP = 4, QUEEN = 5, KING = 6, EDGE = 7;
    localparam int BLK = 8;

    always #2 clk = ~clk;  // 250 MHz

    piece_move_gen i_piece_move_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_cell(wr_cell),
        .start(start), .start_idx(start_idx), .mv_valid(mv_valid), .mv_ready(mv_ready),
        .mv_src(mv_src), .mv_dst(mv_dst), .mv_capture(mv_capture), .done(done)
    );

    function automatic int sq(input int r, input int c);
        return (r + 2) * 12 + (c + 2);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 8'(idx); wr_cell = 4'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_board();
        for (int i = 0; i < 144; i++) begin
            int r, c;
            r = i / 12; c = i % 12;
            put(i, (r < 2 || r > 9 || c < 2 || c > 9) ? EDGE : 0);
        end
    endtask

    // Run one generation; stall selects a ready pattern, poke>=0 injects a start mid-run
    task automatic run_gen(input int idx, input bit stall, input int poke, input string req);
        int cyc;
        bit fin;
        n_got = 0; done_at = -1; fin = 0; cyc = 0;
        mv_ready = 1'b1;
        @(negedge clk);
        start = 1'b1; start_idx = 8'(idx);
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 3000) begin
            if (done) begin
                fin = 1; done_at = cyc;
            end else begin
                bit held;
                int h_dst, h_src, h_cap;
                held = 0;
                if (mv_valid && mv_ready) begin
                    if (n_got < 64) begin
                        got_dst[n_got] = int'(mv_dst);
                        got_cap[n_got] = int'(mv_capture);
                    end
                    n_got++;
                    check(mv_src == 8'(idx), {req, " R9 source index"}, int'(mv_src), idx);
                end else if (mv_valid) begin
                    held = 1; h_dst = int'(mv_dst); h_src = int'(mv_src); h_cap = int'(mv_capture);
                end
                if (poke >= 0 && cyc == 2) begin
                    start = 1'b1; start_idx = 8'(poke);
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                cyc++;
                mv_ready = stall ? ((cyc % 3) == 2) : 1'b1;
                if (held) begin
                    check(mv_valid && int'(mv_dst) == h_dst && int'(mv_src) == h_src && int'(mv_capture) == h_cap,
                          "R8 stall hold", int'(mv_dst), h_dst);
                end
            end
        end
        start = 1'b0;
        mv_ready = 1'b1;
        check(fin, {req, " R9 done reached"}, int'(fin), 1);
        @(negedge clk);
        check(!done, {req, " R9 done one cycle"}, int'(done), 0);
    endtask

    task automatic expect_count(input int n, input string req);
        check(n_got == n, {req, " move count"}, n_got, n);
    endtask

    task automatic expect_move(input int r, input int c, input int cap, input string req);
        int hit;
        hit = -1;
        for (int i = 0; i < n_got && i < 64; i++) if (got_dst[i] == sq(r, c)) hit = got_cap[i];
        check(hit == cap, {req, " move present/capture"}, hit, cap);
    endtask

    task automatic expect_absent(input int r, input int c, input string req);
        int hit;
        hit = 0;
        for (int i = 0; i < n_got && i < 64; i++) if (got_dst[i] == sq(r, c)) hit = 1;
        check(hit == 0, {req, " move absent"}, hit, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!mv_valid && !done, "R1 reset outputs", int'(mv_valid) + int'(done), 0);
    endtask

    task automatic t_void_start();
        clear_board();
        run_gen(sq(4, 4), 0, -1, "R3 empty");
        check(done_at == 0, "R3 empty start done next cycle", done_at, 0);
        expect_count(0, "R3 empty");
        run_gen(0, 0, -1, "R3 boundary");
        check(done_at == 0, "R3 boundary start done next cycle", done_at, 0);
        expect_count(0, "R3 boundary");
    endtask

    task automatic t_rook();
        clear_board();
        put(sq(0, 0), ROOK);
        run_gen(sq(0, 0), 0, -1, "R4 rook corner");
        expect_count(14, "R4 rook corner");
        expect_move(0, 7, 0, "R4 rook corner");
        expect_move(7, 0, 0, "R4 rook corner");
        clear_board();
        put(sq(3, 3), ROOK);
        put(sq(3, 5), PAWN);
        put(sq(1, 3), BLK + KNIGHT);
        run_gen(sq(3, 3), 0, -1, "R4 rook blocked");
        expect_count(10, "R4 rook blocked");
        expect_move(1, 3, 1, "R4 enemy capture");
        expect_absent(0, 3, "R4 past enemy");
        expect_absent(3, 5, "R4 own piece");
        expect_move(3, 4, 0, "R4 before own");
    endtask

    task automatic t_queen_bishop();
        clear_board();
        put(sq(3, 3), BLK + QUEEN);
        run_gen(sq(3, 3), 0, -1, "R4 queen");
        expect_count(27, "R4 queen");
        expect_move(7, 7, 0, "R4 queen diagonal");
        clear_board();
        put(sq(2, 2), BISHOP);
        put(sq(4, 4), BLK + PAWN);
        put(sq(1, 1), PAWN);
        run_gen(sq(2, 2), 0, -1, "R4 bishop");
        // SE stops at capture (3,3),(4,4); NE (1,3),(0,4); SW (3,1),(4,0); NW own
        expect_count(6, "R4 bishop");
        expect_move(4, 4, 1, "R4 bishop capture");
        expect_absent(1, 1, "R4 bishop own");
    endtask

    task automatic t_knight_king();
        clear_board();
        put(sq(0, 0), KNIGHT);
        run_gen(sq(0, 0), 0, -1, "R5 knight corner");
        expect_count(2, "R5 knight corner");
        expect_move(2, 1, 0, "R5 knight corner");
        clear_board();
        put(sq(4, 4), KNIGHT);
        put(sq(2, 3), KING);
        put(sq(2, 5), BLK + ROOK);
        run_gen(sq(4, 4), 1, -1, "R5 knight middle stalled");
        expect_count(7, "R5 knight middle");
        expect_move(2, 5, 1, "R5 knight capture");
        expect_absent(2, 3, "R5 knight own");
        clear_board();
        put(sq(0, 7), BLK + KING);
        run_gen(sq(0, 7), 0, -1, "R5 king corner");
        expect_count(3, "R5 king corner");
        expect_move(1, 6, 0, "R5 king diagonal");
    endtask

    task automatic t_pawn();
        clear_board();
        put(sq(6, 4), PAWN);
        put(sq(5, 3), BLK + KNIGHT);
        put(sq(5, 5), BISHOP);
        run_gen(sq(6, 4), 0, -1, "R6 white home");
        expect_count(3, "R6 white home");
        expect_move(4, 4, 0, "R6 double push");
        expect_move(5, 3, 1, "R7 diagonal enemy");
        expect_absent(5, 5, "R7 diagonal own");
        put(sq(4, 4), BLK + PAWN);
        run_gen(sq(6, 4), 0, -1, "R6 second blocked");
        expect_count(2, "R6 second blocked");
        expect_absent(4, 4, "R6 no capture straight");
        put(sq(5, 4), BLK + PAWN);
        run_gen(sq(6, 4), 0, -1, "R6 first blocked");
        expect_count(1, "R6 first blocked");
        clear_board();
        put(sq(1, 2), BLK + PAWN);
        run_gen(sq(1, 2), 0, -1, "R6 black home");
        expect_count(2, "R6 black home");
        expect_move(3, 2, 0, "R6 black double");
        clear_board();
        put(sq(2, 2), BLK + PAWN);
        put(sq(3, 1), PAWN);
        run_gen(sq(2, 2), 0, -1, "R6 black not home");
        expect_count(2, "R6 black not home");
        expect_absent(4, 2, "R6 no double off home");
        expect_move(3, 1, 1, "R7 black capture");
    endtask

    task automatic t_busy_and_retain();
        clear_board();
        put(sq(0, 0), ROOK);
        put(sq(5, 5), KNIGHT);
        run_gen(sq(0, 0), 1, sq(5, 5), "R9 start while busy");
        expect_count(14, "R9 start while busy");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!mv_valid && !done, "R1 reset mid-life outputs", int'(mv_valid), 0);
        run_gen(sq(5, 5), 0, -1, "R1 board kept");
        expect_count(8, "R1 board kept");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_void_start();
        t_rook();
        t_queen_bishop();
        t_knight_king();
        t_pawn();
        t_busy_and_retain();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule